// File: doc/BRIEF.md
# Triangle Setup and Culling Unit

This unit receives one projected triangle per handshake: three screen-space vertices (x, y and depth), the z component of the transformed normal, and a flat RGB color. If the normal points away from the viewer, the triangle is thrown away at once and no arithmetic is spent on it. A surviving triangle has its vertices ordered top to bottom. The unit then works out the depth-plane terms and the edge slopes, and cuts the triangle at the row of its middle vertex into at most two flat-edged half triangles.

Each half triangle leaves on a valid/ready stream as one record, ready for a downstream task FIFO. A record carries the row span, a start x, a left and a right slope, the plane constant, the negated reciprocal of the plane's z coefficient, and the color. With these precomputed values a scanline filler needs only multiplies and adds. All quotients come from a single shared radix-2 divider that takes several cycles per division, and the input is held off while setup is running.

Top module: `tri_setup_unit`

## Requirements
- R1: `inReady` is high after reset and in the idle state only. Once a triangle with positive normal z is accepted, `inReady` goes low from the next cycle and stays low until the last record of that triangle has been taken. It is always low while the divider is busy.
- R2: A triangle whose signed `inNormZ` is zero or negative is consumed in one handshake. It produces no record, and `inReady` stays high.
- R3: Vertices are ordered by ascending signed y into top A, middle B and bottom C. Equal y values keep their input index order (index 0 before 1 before 2).
- R4: A triangle with yA equal to yC, or with plane coefficient C equal to zero, is dropped without any record.
- R5: The upper half (`outLower`=0) is emitted when yB > yA. Its fields are top yA, bottom yB, start x xA, left slope = min(sAB, sAC) and right slope = max(sAB, sAC).
- R6: The lower half (`outLower`=1) is emitted when yC > yB, after any upper half of the same triangle. Its fields are top yB, bottom yC, start x xC (the rasterizer walks upward from the bottom apex), left slope = max(sBC, sAC) and right slope = min(sBC, sAC).
- R7: Slope sPQ = ((xQ-xP)·2^16)/(yQ-yP), as a 32-bit signed value with 16 fraction bits, truncated toward zero. A zero denominator gives 0.
- R8: With e1 = B-A and e2 = C-A, the coefficients are A = e1y·e2z - e1z·e2y, B = e1z·e2x - e1x·e2z and C = e1x·e2y - e1y·e2x. `outDepthD` = -(A·xA + B·yA + C·zA) as a 48-bit signed value. `outInvC` = -2^16 / C, truncated toward zero, as a 32-bit signed value.
- R9: Both halves carry the input color unchanged.
- R10: A triangle with a flat top (yA = yB) or a flat bottom (yB = yC) produces exactly one record, and every other surviving triangle produces exactly two.
- R11: While `outValid` is high and `outReady` is low, `outValid` and every record field stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Triangle present |
| inReady | output | 1 | Unit can accept a triangle |
| inX | input | 3×COORD_W | Signed x of vertices 0..2 |
| inY | input | 3×COORD_W | Signed y of vertices 0..2 |
| inZ | input | 3×Z_W | Signed depth of vertices 0..2 |
| inNormZ | input | Z_W | Signed z of the transformed normal |
| inColor | input | COLOR_W | Flat RGB color |
| outValid | output | 1 | Half-triangle record present |
| outReady | input | 1 | Downstream accepts the record |
| outTopY | output | COORD_W | First row of the half |
| outBotY | output | COORD_W | Last row of the half |
| outStartX | output | COORD_W | Apex x of the half |
| outLeftSlope | output | SLOPE_W | Left edge dx/dy, 16 fraction bits |
| outRightSlope | output | SLOPE_W | Right edge dx/dy, 16 fraction bits |
| outDepthD | output | DEPTH_W | Plane constant D |
| outInvC | output | SLOPE_W | -1/C, 16 fraction bits |
| outColor | output | COLOR_W | Triangle color |
| outLower | output | 1 | 0 = upper half, 1 = lower half |

## Verification
On every cycle the assertions check the following: the input is refused while the divider runs, a culled triangle leaves the unit idle with no record, an emitted half never has zero height, each half's left and right slopes are in the order its walking direction needs, and a stalled record holds still. The bench scenarios are needed for the arithmetic itself: the ordering of tied and unsorted vertices, truncation of fractional slopes toward zero, the plane constant and -1/C, and the count and order of halves for flat-topped, flat-bottomed, collinear and zero-height triangles. These are compared field by field against values worked out from the requirements, under random output stalls.

// File: rtl/tri_setup_pkg.sv
package tri_setup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_DIV_GO, ST_DIV_WAIT, ST_EMIT_UP, ST_EMIT_LO
  } setupState_t;

  // control -> datapath
  typedef struct packed {
    logic       load;
    logic       divStart;
    logic [1:0] divSel;
    logic       emitLower;
  } setupStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic zeroHeight;
    logic zeroArea;
    logic hasUpper;
    logic hasLower;
    logic divDone;
  } setupStatus_t;

  // division order; the last one closes setup
  localparam logic [1:0] DIV_AB   = 2'd0;
  localparam logic [1:0] DIV_AC   = 2'd1;
  localparam logic [1:0] DIV_BC   = 2'd2;
  localparam logic [1:0] DIV_INVC = 2'd3;

endpackage

// File: rtl/tri_setup_div.sv
module tri_setup_div #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic signed [W-1:0] numIn,
  input  logic signed [W-1:0] denIn,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] quot
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem, quo, den;
  logic [CNT_W-1:0] cnt;
  logic             neg, zeroDen;
  logic [W:0]       shifted, diff;

  assign shifted = {rem, quo[W-1]};
  assign diff    = shifted - {1'b0, den};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem <= '0; quo <= '0; den <= '0; cnt <= '0;
      neg <= 1'b0; zeroDen <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem     <= '0;
        quo     <= numIn[W-1] ? -numIn : numIn;
        den     <= denIn[W-1] ? -denIn : denIn;
        neg     <= numIn[W-1] ^ denIn[W-1];
        zeroDen <= (denIn == '0);
        cnt     <= CNT_W'(W);
        busy    <= 1'b1;
      end else if (busy) begin
        // restoring step: keep the difference when no borrow
        quo <= {quo[W-2:0], ~diff[W]};
        rem <= diff[W] ? shifted[W-1:0] : diff[W-1:0];
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = zeroDen ? '0 : (neg ? -$signed(quo) : $signed(quo));

  // R7: one result pulse per division
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy);

endmodule

// File: rtl/tri_setup_dp.sv
module tri_setup_dp
  import tri_setup_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int Z_W     = 16,
  parameter int COLOR_W = 24,
  parameter int FRAC_W  = 16,
  parameter int SLOPE_W = 32,
  parameter int DEPTH_W = 48
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  setupStrobe_t               strobe,
  output setupStatus_t               status,
  output logic                       divBusy,
  input  logic [2:0][COORD_W-1:0]    inX,
  input  logic [2:0][COORD_W-1:0]    inY,
  input  logic [2:0][Z_W-1:0]        inZ,
  input  logic [COLOR_W-1:0]         inColor,
  output logic signed [COORD_W-1:0]  outTopY,
  output logic signed [COORD_W-1:0]  outBotY,
  output logic signed [COORD_W-1:0]  outStartX,
  output logic signed [SLOPE_W-1:0]  outLeftSlope,
  output logic signed [SLOPE_W-1:0]  outRightSlope,
  output logic signed [DEPTH_W-1:0]  outDepthD,
  output logic signed [SLOPE_W-1:0]  outInvC,
  output logic [COLOR_W-1:0]         outColor,
  output logic                       outLower
);
  localparam int EDGE_W = COORD_W + 1;
  localparam int ZE_W   = Z_W + 1;
  localparam logic signed [SLOPE_W-1:0] NEG_ONE_FIX = -(SLOPE_W'(1) << FRAC_W);

  logic signed [COORD_W-1:0] sortX [3], sortY [3], vx [3], vy [3];
  logic signed [Z_W-1:0]     sortZ [3], vz [3];
  logic [COLOR_W-1:0]        color;
  logic signed [SLOPE_W-1:0] slopeAB, slopeAC, slopeBC, invC;
  logic [1:0]                selReg;

  // stable rank by y: a vertex ranks after every lower y and every earlier tie
  always_comb begin
    for (int k = 0; k < 3; k++) begin
      sortX[k] = '0; sortY[k] = '0; sortZ[k] = '0;
    end
    for (int i = 0; i < 3; i++) begin
      logic [1:0] rank;
      rank = 2'd0;
      for (int j = 0; j < 3; j++)
        if (j != i && ($signed(inY[j]) < $signed(inY[i]) ||
                       (inY[j] == inY[i] && j < i)))
          rank = rank + 2'd1;
      sortX[rank] = $signed(inX[i]);
      sortY[rank] = $signed(inY[i]);
      sortZ[rank] = $signed(inZ[i]);
    end
  end

  // edges and plane
  logic signed [EDGE_W-1:0]  e1x, e1y, e2x, e2y, e3x, e3y;
  logic signed [ZE_W-1:0]    e1z, e2z;
  logic signed [DEPTH_W-1:0] planeA, planeB, planeC, planeD;

  assign e1x = EDGE_W'(vx[1]) - EDGE_W'(vx[0]);
  assign e1y = EDGE_W'(vy[1]) - EDGE_W'(vy[0]);
  assign e2x = EDGE_W'(vx[2]) - EDGE_W'(vx[0]);
  assign e2y = EDGE_W'(vy[2]) - EDGE_W'(vy[0]);
  assign e3x = EDGE_W'(vx[2]) - EDGE_W'(vx[1]);
  assign e3y = EDGE_W'(vy[2]) - EDGE_W'(vy[1]);
  assign e1z = ZE_W'(vz[1]) - ZE_W'(vz[0]);
  assign e2z = ZE_W'(vz[2]) - ZE_W'(vz[0]);

  assign planeA = DEPTH_W'(e1y) * DEPTH_W'(e2z) - DEPTH_W'(e1z) * DEPTH_W'(e2y);
  assign planeB = DEPTH_W'(e1z) * DEPTH_W'(e2x) - DEPTH_W'(e1x) * DEPTH_W'(e2z);
  assign planeC = DEPTH_W'(e1x) * DEPTH_W'(e2y) - DEPTH_W'(e1y) * DEPTH_W'(e2x);
  assign planeD = -(planeA * DEPTH_W'(vx[0]) + planeB * DEPTH_W'(vy[0]) +
                    planeC * DEPTH_W'(vz[0]));

  // divider operand select
  logic signed [SLOPE_W-1:0] divNum, divDen, divQuot;
  logic                      divDone;

  always_comb begin
    case (strobe.divSel)
      DIV_AB:  begin divNum = SLOPE_W'(e1x) <<< FRAC_W; divDen = SLOPE_W'(e1y); end
      DIV_AC:  begin divNum = SLOPE_W'(e2x) <<< FRAC_W; divDen = SLOPE_W'(e2y); end
      DIV_BC:  begin divNum = SLOPE_W'(e3x) <<< FRAC_W; divDen = SLOPE_W'(e3y); end
      default: begin divNum = NEG_ONE_FIX;              divDen = SLOPE_W'(planeC); end
    endcase
  end

  tri_setup_div #(.W(SLOPE_W)) uDiv (
    .clk(clk), .rstN(rstN), .start(strobe.divStart),
    .numIn(divNum), .denIn(divDen),
    .busy(divBusy), .done(divDone), .quot(divQuot)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 3; k++) begin vx[k] <= '0; vy[k] <= '0; vz[k] <= '0; end
      color <= '0; selReg <= '0;
      slopeAB <= '0; slopeAC <= '0; slopeBC <= '0; invC <= '0;
    end else begin
      if (strobe.load) begin
        for (int k = 0; k < 3; k++) begin
          vx[k] <= sortX[k]; vy[k] <= sortY[k]; vz[k] <= sortZ[k];
        end
        color <= inColor;
      end
      if (strobe.divStart) selReg <= strobe.divSel;
      if (divDone) begin
        case (selReg)
          DIV_AB:  slopeAB <= divQuot;
          DIV_AC:  slopeAC <= divQuot;
          DIV_BC:  slopeBC <= divQuot;
          default: invC    <= divQuot;
        endcase
      end
    end
  end

  assign status.zeroHeight = (vy[0] == vy[2]);
  assign status.zeroArea   = (planeC == '0);
  assign status.hasUpper   = (vy[1] > vy[0]);
  assign status.hasLower   = (vy[2] > vy[1]);
  assign status.divDone    = divDone;

  // record assembly
  always_comb begin
    if (strobe.emitLower) begin
      outTopY       = vy[1];
      outBotY       = vy[2];
      outStartX     = vx[2];
      outLeftSlope  = (slopeBC > slopeAC) ? slopeBC : slopeAC;
      outRightSlope = (slopeBC > slopeAC) ? slopeAC : slopeBC;
    end else begin
      outTopY       = vy[0];
      outBotY       = vy[1];
      outStartX     = vx[0];
      outLeftSlope  = (slopeAB < slopeAC) ? slopeAB : slopeAC;
      outRightSlope = (slopeAB < slopeAC) ? slopeAC : slopeAB;
    end
  end

  assign outDepthD = planeD;
  assign outInvC   = invC;
  assign outColor  = color;
  assign outLower  = strobe.emitLower;

endmodule

// File: rtl/tri_setup_ctrl.sv
module tri_setup_ctrl
  import tri_setup_pkg::*;
#(
  parameter int Z_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic signed [Z_W-1:0] inNormZ,
  input  logic                  outReady,
  input  setupStatus_t          status,
  output logic                  inReady,
  output logic                  outValid,
  output setupStrobe_t          strobe
);
  setupState_t state, nextState;
  logic [1:0]  divIdx, nextIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divIdx <= '0;
    end else begin
      state  <= nextState;
      divIdx <= nextIdx;
    end
  end

  always_comb begin
    nextState = state;
    nextIdx   = divIdx;
    strobe    = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        // back faces are consumed here and never loaded
        if (inValid && inNormZ > 0) begin
          strobe.load = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.zeroHeight || status.zeroArea) nextState = ST_IDLE;
        else begin
          nextIdx   = DIV_AB;
          nextState = ST_DIV_GO;
        end
      end
      ST_DIV_GO: begin
        strobe.divStart = 1'b1;
        strobe.divSel   = divIdx;
        nextState       = ST_DIV_WAIT;
      end
      ST_DIV_WAIT: begin
        if (status.divDone) begin
          if (divIdx == DIV_INVC)
            nextState = status.hasUpper ? ST_EMIT_UP : ST_EMIT_LO;
          else begin
            nextIdx   = divIdx + 2'd1;
            nextState = ST_DIV_GO;
          end
        end
      end
      ST_EMIT_UP: begin
        outValid = 1'b1;
        if (outReady) nextState = status.hasLower ? ST_EMIT_LO : ST_IDLE;
      end
      ST_EMIT_LO: begin
        outValid         = 1'b1;
        strobe.emitLower = 1'b1;
        if (outReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R6: the lower half of a triangle never precedes its upper half
  assert_upper_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EMIT_LO) |=> (state != ST_EMIT_UP));

endmodule

// File: rtl/tri_setup_unit.sv
module tri_setup_unit
  import tri_setup_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int Z_W     = 16,
  parameter int COLOR_W = 24,
  parameter int FRAC_W  = 16,
  parameter int SLOPE_W = 32,
  parameter int DEPTH_W = 48
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [2:0][COORD_W-1:0]   inX,
  input  logic [2:0][COORD_W-1:0]   inY,
  input  logic [2:0][Z_W-1:0]       inZ,
  input  logic signed [Z_W-1:0]     inNormZ,
  input  logic [COLOR_W-1:0]        inColor,
  output logic                      outValid,
  input  logic                      outReady,
  output logic signed [COORD_W-1:0] outTopY,
  output logic signed [COORD_W-1:0] outBotY,
  output logic signed [COORD_W-1:0] outStartX,
  output logic signed [SLOPE_W-1:0] outLeftSlope,
  output logic signed [SLOPE_W-1:0] outRightSlope,
  output logic signed [DEPTH_W-1:0] outDepthD,
  output logic signed [SLOPE_W-1:0] outInvC,
  output logic [COLOR_W-1:0]        outColor,
  output logic                      outLower
);
  setupStrobe_t strobe;
  setupStatus_t status;
  logic         divBusy;

  tri_setup_ctrl #(.Z_W(Z_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inNormZ(inNormZ),
    .outReady(outReady), .status(status),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  tri_setup_dp #(
    .COORD_W(COORD_W), .Z_W(Z_W), .COLOR_W(COLOR_W),
    .FRAC_W(FRAC_W), .SLOPE_W(SLOPE_W), .DEPTH_W(DEPTH_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status), .divBusy(divBusy),
    .inX(inX), .inY(inY), .inZ(inZ), .inColor(inColor),
    .outTopY(outTopY), .outBotY(outBotY), .outStartX(outStartX),
    .outLeftSlope(outLeftSlope), .outRightSlope(outRightSlope),
    .outDepthD(outDepthD), .outInvC(outInvC), .outColor(outColor),
    .outLower(outLower)
  );

  assert_busy_blocks_input_R1: assert property (@(posedge clk) disable iff (!rstN)
    divBusy |-> !inReady);

  assert_cull_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inNormZ <= 0) |=> (inReady && !outValid));

  assert_height_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outTopY < outBotY));

  assert_upper_edges_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLower) |-> (outLeftSlope <= outRightSlope));

  assert_lower_edges_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLower) |-> (outLeftSlope >= outRightSlope));

  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable({outTopY, outBotY, outStartX,
      outLeftSlope, outRightSlope, outDepthD, outInvC, outColor, outLower})));

endmodule

// File: tb/tri_setup_unit_test.sv
module tri_setup_unit_test;
  localparam int CW = 12, ZW = 16, LW = 24, SW = 32, DW = 48;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rstN, inValid, inReady, outValid, outReady, outLower;
  logic [2:0][CW-1:0]   inX, inY;
  logic [2:0][ZW-1:0]   inZ;
  logic signed [ZW-1:0] inNormZ;
  logic [LW-1:0]        inColor, outColor;
  logic signed [CW-1:0] outTopY, outBotY, outStartX;
  logic signed [SW-1:0] outLeftSlope, outRightSlope, outInvC;
  logic signed [DW-1:0] outDepthD;

  tri_setup_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inX(inX), .inY(inY), .inZ(inZ), .inNormZ(inNormZ), .inColor(inColor),
    .outValid(outValid), .outReady(outReady),
    .outTopY(outTopY), .outBotY(outBotY), .outStartX(outStartX),
    .outLeftSlope(outLeftSlope), .outRightSlope(outRightSlope),
    .outDepthD(outDepthD), .outInvC(outInvC), .outColor(outColor),
    .outLower(outLower)
  );

  typedef struct {
    int top, bot, sx, col;
    longint ls, rs, d, ic;
    bit lower;
  } rec_t;

  rec_t expQ[$];
  int   checks = 0, failures = 0;
  bit   stallOn = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic longint slope(input longint dx, input longint dy);
    return (dy == 0) ? 0 : (dx * 65536) / dy;
  endfunction

  // driver: predicts the records, then hands the triangle over
  task automatic sendTri(input int xs[3], input int ys[3], input int zs[3],
                         input int nz, input int col);
    int ord[3];
    longint ax, ay, az, bx, by, bz, cx, cy, cz, a, b, c, sab, sac, sbc;
    rec_t r;
    for (int i = 0; i < 3; i++) begin
      int pos;
      pos = 0;
      for (int j = 0; j < 3; j++)
        if (j != i && (ys[j] < ys[i] || (ys[j] == ys[i] && j < i))) pos++;
      ord[pos] = i;
    end
    ax = xs[ord[0]]; ay = ys[ord[0]]; az = zs[ord[0]];
    bx = xs[ord[1]]; by = ys[ord[1]]; bz = zs[ord[1]];
    cx = xs[ord[2]]; cy = ys[ord[2]]; cz = zs[ord[2]];
    a = (by-ay)*(cz-az) - (bz-az)*(cy-ay);
    b = (bz-az)*(cx-ax) - (bx-ax)*(cz-az);
    c = (bx-ax)*(cy-ay) - (by-ay)*(cx-ax);
    sab = slope(bx-ax, by-ay); sac = slope(cx-ax, cy-ay); sbc = slope(cx-bx, cy-by);
    if (nz > 0 && ay != cy && c != 0) begin
      r.d = -(a*ax + b*ay + c*az); r.ic = -65536 / c; r.col = col;
      if (by > ay) begin
        r.top = int'(ay); r.bot = int'(by); r.sx = int'(ax); r.lower = 0;
        r.ls = (sab < sac) ? sab : sac; r.rs = (sab < sac) ? sac : sab;
        expQ.push_back(r);
      end
      if (cy > by) begin
        r.top = int'(by); r.bot = int'(cy); r.sx = int'(cx); r.lower = 1;
        r.ls = (sbc > sac) ? sbc : sac; r.rs = (sbc > sac) ? sac : sbc;
        expQ.push_back(r);
      end
    end
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      inX[i] = CW'(xs[i]); inY[i] = CW'(ys[i]); inZ[i] = ZW'(zs[i]);
    end
    inNormZ = ZW'(nz); inColor = LW'(col); inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    if (nz > 0) chk(!inReady, "R1 inReady low after accepting front face", longint'(inReady), 0);
    else        chk(inReady && !outValid, "R2 culled triangle leaves unit idle",
                    longint'({inReady, outValid}), 2);
  endtask

  task automatic cmpRec();
    rec_t e;
    string t;
    if (expQ.size() == 0) begin
      chk(1'b0, "R2 R4 R10 unexpected record, top", longint'(outTopY), -1);
      return;
    end
    e = expQ.pop_front();
    t = e.lower ? "R6" : "R5";
    chk(outLower == e.lower, "R10 half order/flag", longint'(outLower), longint'(e.lower));
    chk(int'(outTopY) == e.top, {t, " R3 top y"}, longint'(outTopY), e.top);
    chk(int'(outBotY) == e.bot, {t, " R3 bottom y"}, longint'(outBotY), e.bot);
    chk(int'(outStartX) == e.sx, {t, " start x"}, longint'(outStartX), e.sx);
    chk(longint'(outLeftSlope) == e.ls, {t, " R7 left slope"}, longint'(outLeftSlope), e.ls);
    chk(longint'(outRightSlope) == e.rs, {t, " R7 right slope"}, longint'(outRightSlope), e.rs);
    chk(longint'(outDepthD) == e.d, "R8 plane D", longint'(outDepthD), e.d);
    chk(longint'(outInvC) == e.ic, "R8 minus 1/C", longint'(outInvC), e.ic);
    chk(int'(outColor) == e.col, "R9 color", longint'(outColor), e.col);
  endtask

  logic [204:0] snapNow;
  assign snapNow = {outTopY, outBotY, outStartX, outLeftSlope, outRightSlope,
                    outDepthD, outInvC, outColor, outLower};

  // monitor: drives ready, checks stall stability, pops the scoreboard
  initial begin
    logic [204:0] prevSnap;
    bit stalled;
    stalled = 0; prevSnap = '0; outReady = 1'b1;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (stalled)
          chk(outValid && snapNow == prevSnap, "R11 record held while stalled",
              longint'(outValid), 1);
        outReady = stallOn ? ($urandom_range(0, 2) != 0) : 1'b1;
        if (outValid && outReady) cmpRec();
        stalled  = outValid && !outReady;
        prevSnap = snapNow;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inX = '0; inY = '0; inZ = '0; inNormZ = '0; inColor = '0;
    repeat (3) @(negedge clk);
    chk(!outValid && inReady, "R1 reset state", longint'({inReady, outValid}), 2);
    rstN = 1'b1;

    sendTri('{0, 8, -4}, '{0, 4, 8}, '{100, 200, 300}, 1, 24'h112233);   // both halves
    sendTri('{0, 10, 4}, '{2, 2, 9}, '{5, -5, 40}, 7, 24'hA0B0C0);       // R10 flat top
    sendTri('{5, 0, 12}, '{0, 7, 7}, '{-3, 9, 1}, 3, 24'h010203);        // R10 flat bottom
    sendTri('{1, 9, 4}, '{0, 3, 8}, '{1, 2, 3}, 0, 24'hFFFFFF);          // R2 zero normal
    sendTri('{1, 9, 4}, '{0, 3, 8}, '{1, 2, 3}, -5, 24'hFFFFFF);         // R2 back face
    sendTri('{1, 9, 4}, '{3, 3, 3}, '{1, 2, 3}, 2, 24'h00FF00);          // R4 zero height
    sendTri('{0, 1, 2}, '{0, 1, 2}, '{7, 8, 9}, 2, 24'h0000FF);          // R4 collinear
    sendTri('{-7, 3, 11}, '{9, 1, 5}, '{30, -70, 12}, 4, 24'h445566);    // R3 unsorted
    sendTri('{1, 6, 3}, '{4, 4, 10}, '{10, -20, 30}, 1, 24'h778899);     // R3 tie order
    sendTri('{0, 1, -1}, '{0, 3, 3}, '{0, 0, 0}, 1, 24'h123456);         // R7 truncation
    sendTri('{-2048, 2047, 0}, '{-2048, 2047, 0}, '{-32768, 32767, 0}, 1, 24'hABCDEF);
    sendTri('{-2048, 2047, 100}, '{-2048, 2047, -500}, '{-32768, 32767, 5}, 9, 24'hFEDCBA);

    stallOn = 1;
    for (int n = 0; n < 40; n++) begin
      int xs[3], ys[3], zs[3];
      for (int i = 0; i < 3; i++) begin
        xs[i] = int'($urandom_range(0, 4095)) - 2048;
        ys[i] = int'($urandom_range(0, 63)) - 32;
        zs[i] = int'($urandom_range(0, 65535)) - 32768;
      end
      sendTri(xs, ys, zs, int'($urandom_range(0, 200)) - 60, int'($urandom_range(0, 16777215)));
    end

    repeat (3000) begin
      @(negedge clk);
      if (expQ.size() == 0 && inReady) break;
    end
    repeat (20) @(negedge clk);
    chk(expQ.size() == 0, "R10 every predicted half emitted", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule